// File: doc/BRIEF.md
# Static Memory Access Phase Sequencer

This block produces the control-strobe timing for one asynchronous access to an external static memory, such as an SRAM, a ROM or a NOR-type flash. A request is taken only while the block is idle. It runs through up to three phases of programmable length: address setup, an optional address hold, and data. During these phases it drives chip enable, output enable or write enable, an address-valid strobe and the enable of the write-data bus. When the data phase ends, it stores the read data and gives a one-cycle completion pulse.

The phase lengths come from packed 32-bit timing words. When the extended flag is clear, both directions use the read word and its access-mode field is ignored. When the extended flag is set, reads use the read word and writes use the write word, and the access-mode field can select the hold-phase style of access. The multiplexed flag also turns on the hold phase, and it raises a zero setup value to one. The block takes a copy of the timing, the direction, the address and the write data on the cycle it accepts a request. A change on any of these inputs afterwards does not affect the access in progress.

Top module: `smc_phase_seq`

## Requirements
- R1: While reset is held, and at any time the block is idle, `mem_ce_n_o`, `mem_oe_n_o`, `mem_we_n_o` and `mem_adv_n_o` are high, and `busy_o`, `done_o` and `mem_dq_oe_o` are low.
- R2: The timing word fields are: bits [3:0] address setup, bits [7:4] address hold, bits [15:8] data phase, bits [29:28] access mode. The setup phase lasts exactly the setup value in clocks. `mem_adv_n_o` is low in the setup phase and only there.
- R3: The data phase lasts the data value plus one clock. In that phase, and only in that phase, `mem_oe_n_o` is low for a read or `mem_we_n_o` is low for a write. `mem_ce_n_o` is low through every phase of the access.
- R4: When no hold phase is in use, a setup value of 0 gives a setup phase of zero length.
- R5: A hold phase lasting the hold value in clocks is inserted only when `mux_en_i` is high, or when `ext_en_i` is high and the access mode of the selected word is 3. In all other cases it is skipped.
- R6: When a hold phase is in use, a setup value of 0 is treated as 1.
- R7: With `ext_en_i` high, reads time from `tim_rd_i` and writes time from `tim_wr_i`. With `ext_en_i` low, both directions time from `tim_rd_i`.
- R8: With `ext_en_i` low, the access-mode field has no effect.
- R9: `rdata_o` holds the value `mem_dq_i` had on the last clock of the data phase. `done_o` is high for exactly the one clock after that last data clock.
- R10: `busy_o` is high from the clock after acceptance through the `done_o` clock. A request raised while busy is ignored and does not start another access.
- R11: The timing, direction, address and write data are captured at acceptance. `mem_addr_o` keeps the accepted address through the access, even if the inputs change.
- R12: In a write, `mem_dq_oe_o` is high and `mem_dq_o` carries the accepted write data during the data phase and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, taken when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DQ_W | Write data |
| tim_rd_i | input | 32 | Read (or common) timing word |
| tim_wr_i | input | 32 | Write timing word, used in extended mode |
| ext_en_i | input | 1 | Extended mode: split timing, mode field honoured |
| mux_en_i | input | 1 | Multiplexed address/data memory |
| mem_dq_i | input | DQ_W | Data bus from memory |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DQ_W | Captured read data |
| mem_addr_o | output | ADDR_W | Address to memory |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_adv_n_o | output | 1 | Address valid, active low |
| mem_dq_oe_o | output | 1 | Drive enable for write data |
| mem_dq_o | output | DQ_W | Write data to memory |

## Verification
The two functions that can fall in the same cycle are the sampling of read data and the phase transition that ends the access. The bench provokes this by changing `mem_dq_i` on every data-phase clock. It then checks that `rdata_o` holds only the value from the final data clock and that `done_o` rises on the next clock. In a second case, a new request and changed timing inputs are applied in the middle of an access. The bench checks that the running phase counts and the held address are unaffected, and that no second access begins once the first one ends.

// File: rtl/smc_seq_pkg.sv
package smc_seq_pkg;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned SETUP_LSB = 0;
  localparam int unsigned SETUP_W   = 4;
  localparam int unsigned HOLD_LSB  = 4;
  localparam int unsigned HOLD_W    = 4;
  localparam int unsigned DATA_LSB  = 8;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned MODE_LSB  = 28;
  localparam int unsigned MODE_W    = 2;
  localparam logic [MODE_W-1:0] MODE_WITH_HOLD = 2'b11;

  localparam int unsigned CNT_W_A = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
  localparam int unsigned CNT_W   = (CNT_W_A > DATA_W) ? CNT_W_A : DATA_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HOLD,
    PH_DATA,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic [SETUP_W-1:0] setup;
    logic [HOLD_W-1:0]  hold;
    logic [DATA_W-1:0]  data_m1;
  } phase_plan_t;
endpackage

// File: rtl/smc_timing_sel.sv
module smc_timing_sel
  import smc_seq_pkg::*;
(
  input  logic             we_i,
  input  logic             ext_en_i,
  input  logic             mux_en_i,
  input  logic [CFG_W-1:0] tim_rd_i,
  input  logic [CFG_W-1:0] tim_wr_i,
  output phase_plan_t      plan_o
);
  logic [CFG_W-1:0]   word;
  logic [MODE_W-1:0]  mode;
  logic               hold_used;
  logic [SETUP_W-1:0] setup_raw;
  logic               unused_bits;

  // split timing only in extended mode
  assign word      = (ext_en_i && we_i) ? tim_wr_i : tim_rd_i;
  assign mode      = ext_en_i ? word[MODE_LSB +: MODE_W] : '0;
  assign hold_used = mux_en_i || (mode == MODE_WITH_HOLD);
  assign setup_raw = word[SETUP_LSB +: SETUP_W];

  always_comb begin
    plan_o.setup   = (hold_used && (setup_raw == '0)) ? SETUP_W'(1) : setup_raw;
    plan_o.hold    = hold_used ? word[HOLD_LSB +: HOLD_W] : '0;
    plan_o.data_m1 = word[DATA_LSB +: DATA_W];
  end

  assign unused_bits = ^{word[CFG_W-1:MODE_LSB+MODE_W], word[MODE_LSB-1:DATA_LSB+DATA_W]};
endmodule

// File: rtl/smc_phase_ctr.sv
module smc_phase_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i || (run_i && (cnt_q != '0));

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == '0);

  AST_CTR_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/smc_phase_seq.sv
module smc_phase_seq
  import smc_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DQ_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   wdata_i,
  input  logic [CFG_W-1:0]  tim_rd_i,
  input  logic [CFG_W-1:0]  tim_wr_i,
  input  logic              ext_en_i,
  input  logic              mux_en_i,
  input  logic [DQ_W-1:0]   mem_dq_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DQ_W-1:0]   rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic              mem_adv_n_o,
  output logic              mem_dq_oe_o,
  output logic [DQ_W-1:0]   mem_dq_o
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  phase_plan_t       live_plan, plan_q;
  phase_e            state_q, state_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   wdata_q, rdata_q;
  logic              accept, ph_last, ld, rd_capture;
  logic [CNT_W-1:0]  ld_val;

  smc_timing_sel i_sel (
    .we_i     (we_i),
    .ext_en_i (ext_en_i),
    .mux_en_i (mux_en_i),
    .tim_rd_i (tim_rd_i),
    .tim_wr_i (tim_wr_i),
    .plan_o   (live_plan)
  );

  smc_phase_ctr #(.W(CNT_W)) i_ctr (
    .clk_i      (clk_i),
    .rst_n_i    (rst_q),
    .load_i     (ld),
    .load_val_i (ld_val),
    .run_i      (state_q != PH_IDLE),
    .last_o     (ph_last)
  );

  assign accept = (state_q == PH_IDLE) && req_i;

  // next phase and counter load
  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      PH_IDLE: begin
        if (req_i) begin
          ld = 1'b1;
          if (live_plan.setup != '0) begin
            state_d = PH_SETUP;
            ld_val  = CNT_W'(live_plan.setup) - CNT_W'(1);
          end else if (live_plan.hold != '0) begin
            state_d = PH_HOLD;
            ld_val  = CNT_W'(live_plan.hold) - CNT_W'(1);
          end else begin
            state_d = PH_DATA;
            ld_val  = CNT_W'(live_plan.data_m1);
          end
        end
      end
      PH_SETUP: begin
        if (ph_last) begin
          ld = 1'b1;
          if (plan_q.hold != '0) begin
            state_d = PH_HOLD;
            ld_val  = CNT_W'(plan_q.hold) - CNT_W'(1);
          end else begin
            state_d = PH_DATA;
            ld_val  = CNT_W'(plan_q.data_m1);
          end
        end
      end
      PH_HOLD: begin
        if (ph_last) begin
          ld      = 1'b1;
          state_d = PH_DATA;
          ld_val  = CNT_W'(plan_q.data_m1);
        end
      end
      PH_DATA: begin
        if (ph_last) state_d = PH_DONE;
      end
      PH_DONE:  state_d = PH_IDLE;
      default:  state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  // transaction capture, enabled at acceptance
  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) begin
      plan_q  <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      plan_q  <= live_plan;
      we_q    <= we_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  assign rd_capture = (state_q == PH_DATA) && ph_last && !we_q;

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q)          rdata_q <= '0;
    else if (rd_capture) rdata_q <= mem_dq_i;
  end

  // strobes
  assign busy_o      = (state_q != PH_IDLE);
  assign done_o      = (state_q == PH_DONE);
  assign rdata_o     = rdata_q;
  assign mem_addr_o  = addr_q;
  assign mem_ce_n_o  = !((state_q == PH_SETUP) || (state_q == PH_HOLD) || (state_q == PH_DATA));
  assign mem_adv_n_o = !(state_q == PH_SETUP);
  assign mem_oe_n_o  = !((state_q == PH_DATA) && !we_q);
  assign mem_we_n_o  = !((state_q == PH_DATA) && we_q);
  assign mem_dq_oe_o = (state_q == PH_DATA) && we_q;
  assign mem_dq_o    = wdata_q;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_q)
    !(!mem_oe_n_o && !mem_we_n_o)); // R3
  AST_STROBE_IN_CE: assert property (@(posedge clk_i) disable iff (!rst_q)
    (!mem_oe_n_o || !mem_we_n_o || !mem_adv_n_o) |-> !mem_ce_n_o); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_q)
    !busy_o |-> (mem_ce_n_o && !done_o && !mem_dq_oe_o)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_q)
    done_o |=> !done_o); // R9
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_q)
    done_o |-> $past(!mem_oe_n_o || !mem_we_n_o)); // R9
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_q)
    (busy_o && !done_o) |=> $stable(mem_addr_o)); // R11
  AST_BUSY_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_q)
    (done_o && req_i) |=> !busy_o); // R10
  AST_DQ_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_q)
    mem_dq_oe_o |-> !mem_we_n_o); // R12
endmodule

// File: tb/test_smc_phase_seq.sv
module test_smc_phase_seq;
  localparam int ADDR_W = 20;
  localparam int DQ_W   = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req, we, ext_en, mux_en;
  logic [ADDR_W-1:0] addr;
  logic [DQ_W-1:0]   wdata, dq_in;
  logic [31:0]       tim_rd, tim_wr;
  logic              busy, done, ce_n, oe_n, we_n, adv_n, dq_oe;
  logic [DQ_W-1:0]   rdata, dq_out;
  logic [ADDR_W-1:0] maddr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  smc_phase_seq #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) i_smc_phase_seq (
    .clk_i(clk), .rst_n_i(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .tim_rd_i(tim_rd), .tim_wr_i(tim_wr), .ext_en_i(ext_en),
    .mux_en_i(mux_en), .mem_dq_i(dq_in), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .mem_addr_o(maddr), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n),
    .mem_we_n_o(we_n), .mem_adv_n_o(adv_n), .mem_dq_oe_o(dq_oe), .mem_dq_o(dq_out)
  );

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tword(input int mode, input int dat, input int hld, input int stp);
    return (32'(mode) << 28) | (32'(dat) << 8) | (32'(hld) << 4) | 32'(stp);
  endfunction

  // one access; counts phases at negedges and checks everything against expectations
  task automatic run_access(input bit is_wr, input logic [ADDR_W-1:0] a,
                            input logic [DQ_W-1:0] wd, input int es, input int eh,
                            input int ed, input bit perturb, input string tag);
    int n_s = 0, n_h = 0, n_d = 0, n_busy = 0, dq_err = 0, addr_err = 0, guard = 0;
    logic [31:0] sv_rd, sv_wr;
    bit seen_done = 1'b0;
    sv_rd = tim_rd; sv_wr = tim_wr;
    @(negedge clk);
    req = 1'b1; we = is_wr; addr = a; wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    if (perturb) begin
      req = 1'b1; we = ~is_wr; addr = ~a; wdata = ~wd;
      tim_rd = 32'h0; tim_wr = 32'h0;
    end
    while (!seen_done && guard < 1000) begin
      guard++;
      if (busy) n_busy++;
      if (done) seen_done = 1'b1;
      if (!ce_n) begin
        if (maddr != a) addr_err++;
        if (!adv_n) n_s++;
        else if (oe_n && we_n) n_h++;
      end
      if (!oe_n || !we_n) begin
        n_d++;
        dq_in = 16'hA500 + 16'(n_d);
      end
      if (dq_oe != (is_wr && !we_n)) dq_err++;
      if (is_wr && dq_oe && dq_out != wd) dq_err++;
      if (!is_wr && !we_n) dq_err++;
      if (is_wr && !oe_n) dq_err++;
      if (!seen_done) @(negedge clk);
    end
    check(seen_done, {tag, " R9 done seen"}, int'(seen_done), 1);
    check(n_s == es, {tag, " R2 setup clocks"}, n_s, es);
    check(n_h == eh, {tag, " R5 hold clocks"}, n_h, eh);
    check(n_d == ed, {tag, " R3 data clocks"}, n_d, ed);
    check(n_busy == es + eh + ed + 1, {tag, " R10 busy clocks"}, n_busy, es + eh + ed + 1);
    check(addr_err == 0, {tag, " R11 address held"}, addr_err, 0);
    check(dq_err == 0, {tag, " R12 write bus/strobe"}, dq_err, 0);
    if (!is_wr) check(rdata == 16'hA500 + 16'(ed), {tag, " R9 read sample"}, int'(rdata), 16'hA500 + ed);
    req = 1'b0;
    tim_rd = sv_rd; tim_wr = sv_wr;
    @(negedge clk);
    check(!done, {tag, " R9 done one clock"}, int'(done), 0);
    // request raised while busy (perturb) must not have started a second access
    for (int k = 0; k < 3; k++) begin
      check(!busy && ce_n, {tag, " R10 stays idle"}, int'(busy), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; dq_in = '0;
    ext_en = 1'b0; mux_en = 1'b0; tim_rd = 32'h0FFF_FFFF; tim_wr = 32'h0FFF_FFFF;
    repeat (3) @(negedge clk);
    check(ce_n && oe_n && we_n && adv_n && !busy && !done && !dq_oe, "R1 in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ce_n && oe_n && we_n && adv_n && !busy && !done && !dq_oe, "R1 after reset", int'(busy), 0);
  endtask

  task automatic t_plain_read();   // mode 3 and hold ignored while extended is off
    ext_en = 0; mux_en = 0; tim_rd = tword(3, 3, 5, 2);
    run_access(1'b0, 20'h1_2345, '0, 2, 0, 4, 1'b0, "plain read R8");
  endtask

  task automatic t_zero_setup_write();   // write times from the read word when not extended
    ext_en = 0; mux_en = 0; tim_rd = tword(0, 1, 0, 0); tim_wr = tword(0, 9, 9, 9);
    run_access(1'b1, 20'h0_00F0, 16'h5AC3, 0, 0, 2, 1'b0, "zero setup write R4 R7");
  endtask

  task automatic t_mux_min_setup();
    ext_en = 0; mux_en = 1; tim_rd = tword(0, 0, 2, 0);
    run_access(1'b0, 20'h5_5555, '0, 1, 2, 1, 1'b0, "mux min setup R6");
    tim_rd = tword(0, 0, 0, 3);
    run_access(1'b0, 20'h5_5556, '0, 3, 0, 1, 1'b0, "mux zero hold R5");
    mux_en = 0;
  endtask

  task automatic t_extended();
    ext_en = 1; mux_en = 0; tim_rd = tword(0, 2, 7, 1); tim_wr = tword(3, 5, 1, 4);
    run_access(1'b0, 20'hA_0001, '0, 1, 0, 3, 1'b0, "ext read R7");
    run_access(1'b1, 20'hA_0002, 16'h1234, 4, 1, 6, 1'b0, "ext write R7 R5");
    tim_wr = tword(3, 0, 2, 0);
    run_access(1'b1, 20'hA_0003, 16'hBEEF, 1, 2, 1, 1'b0, "ext mode3 min setup R6");
    ext_en = 0;
  endtask

  task automatic t_perturb();
    ext_en = 0; mux_en = 0; tim_rd = tword(0, 4, 0, 3);
    run_access(1'b0, 20'h3_C3C3, '0, 3, 0, 5, 1'b1, "mid-access change R11 R10");
  endtask

  task automatic t_reset_word();   // reset-value word gives maximum lengths
    ext_en = 0; mux_en = 0; tim_rd = 32'h0FFF_FFFF;
    run_access(1'b0, 20'hF_FFFF, '0, 15, 0, 256, 1'b0, "max lengths R2 R3");
  endtask

  initial begin
    t_reset();
    t_plain_read();
    t_zero_setup_write();
    t_mux_min_setup();
    t_extended();
    t_perturb();
    t_reset_word();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule